// File: doc/BRIEF.md
# Audio Codec Control Register Bank

This block holds the software-visible control state of an audio controller. A bus master reaches eleven 32-bit words through word-aligned byte addresses. Four of the words carry codec register traffic: a command word, a codec register address, outgoing data and incoming data. The remaining words describe two DMA channels, one for playback (downstream) and one for capture (upstream). Each channel has a control word, a buffer address and a remaining count. One slot between the two channel groups is left unused.

A write to the command word can start a codec transaction. When its go bit is set, a single-cycle pulse appears on either the codec write-request line or the codec read-request line, chosen by the direction bit. The go bit is never stored, so it always reads back as zero. Each channel's enable bit is brought out as a level that gates the matching channel engine. The engines advance their buffer address and remaining count through load ports. A software write to the same word in the same cycle wins over the engine load.

Top module: `audreg_top`

## Requirements
- R1: The word index is the byte address shifted right by two, and the low two address bits are ignored. Indices 0..10 hold, in order: command, codec address, codec data out, codec data in, downstream control, downstream address, downstream remaining, an unused slot (7), upstream control, upstream address, upstream remaining.
- R2: A read strobe loads the selected word into `bus_rdata`, which shows it from the cycle after the strobe and holds it until the next read.
- R3: Command word encoding: bit 0 is go and bit 1 is direction (1 = write). A write with bit 0 = 1 and bit 1 = 1 drives `codec_wr_req` high for exactly the one cycle after the write.
- R4: A command write with bit 0 = 1 and bit 1 = 0 drives `codec_rd_req` high for exactly one cycle. A command write with bit 0 = 0 pulses neither line, and the two lines are never high together.
- R5: The command word reads back with bit 0 always 0, and every other written bit is kept.
- R6: Bit 0 of each channel control word (downstream index 4, upstream index 8) drives `dma_enable[0]` or `dma_enable[1]`. The enable changes in the cycle after the write and only through a bus write.
- R7: A write to index 7 or to any index above 10 changes nothing, and a read of such an index returns zero.
- R8: Reset clears every word, the read data, both enables and both request lines to zero.
- R9: A channel's address load or remaining load replaces that word in the next cycle. A bus write to the same word in the same cycle takes priority over the load.
- R10: `codec_reg_addr` and `codec_reg_wdata` always show the codec address word (index 1) and the codec data-out word (index 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (never with bus_wr) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| codec_wr_req | output | 1 | One-cycle codec register write request |
| codec_rd_req | output | 1 | One-cycle codec register read request |
| codec_reg_addr | output | 32 | Codec register address word |
| codec_reg_wdata | output | 32 | Codec data-out word |
| dma_enable | output | 2 | Channel enables, [0] downstream, [1] upstream |
| dma_addr | output | 2x32 | Channel buffer addresses |
| dma_remaining | output | 2x32 | Channel remaining counts |
| dma_addr_load | input | 2 | Engine load strobe for the address word |
| dma_addr_next | input | 2x32 | Engine value for the address word |
| dma_rem_load | input | 2 | Engine load strobe for the remaining word |
| dma_rem_next | input | 2x32 | Engine value for the remaining word |

## Verification
Every result here lands exactly one cycle after its cause: read data after a read strobe, a request pulse after a command write, and a new enable, address or count after a write or an engine load. Stimulus is applied on the falling clock edge and held across one rising edge. The reference model in the bench updates on that rising edge, and all outputs are compared with it on the next falling edge, so each comparison falls in the cycle the result is due. Directed reads check aliasing, the hidden go bit, the unused slots, reset and load priority in that same cycle.

// File: rtl/audreg_pkg.sv
package audreg_pkg;

    localparam int WORD_W    = 32;
    localparam int NUM_WORDS = 11;
    localparam int NUM_CH    = 2;

    // index layout; channel groups are decoded by neighbours at these offsets
    localparam int IDX_CMD     = 0;
    localparam int IDX_CADDR   = 1;
    localparam int IDX_CDOUT   = 2;
    localparam int IDX_CDIN    = 3;
    localparam int IDX_GAP     = 7;
    localparam int CH_BASE     = 4;
    localparam int CH_STRIDE   = 4;
    localparam int CH_OFS_CTRL = 0;
    localparam int CH_OFS_ADDR = 1;
    localparam int CH_OFS_REM  = 2;

    localparam int CMD_GO_BIT  = 0;
    localparam int CMD_DIR_BIT = 1;
    localparam int CH_EN_BIT   = 0;

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        word_t cmd;
        word_t caddr;
        word_t cdout;
        word_t cdin;
        logic  wr_pulse;
        logic  rd_pulse;
    } codec_st_t;

    typedef struct packed {
        word_t ctrl;
        word_t addr;
        word_t rem;
    } chan_st_t;

    function automatic int chan_idx(input int ch, input int ofs);
        return CH_BASE + ch * CH_STRIDE + ofs;
    endfunction

endpackage

// File: rtl/audreg_decode.sv
module audreg_decode
    import audreg_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic [ADDR_W-1:0]    addr,
    output logic [NUM_WORDS-1:0] sel
);
    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] idx;
    logic             unused_low;

    assign idx        = addr[ADDR_W-1:2];
    assign unused_low = ^addr[1:0];

    for (genvar i = 0; i < NUM_WORDS; i++) begin : g_sel
        if (i == IDX_GAP) begin : g_gap
            assign sel[i] = 1'b0;
        end else begin : g_word
            assign sel[i] = (idx == IDX_W'(i));
        end
    end
endmodule

// File: rtl/audreg_codec.sv
module audreg_codec
    import audreg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [3:0] sel,
    input  word_t      wdata,
    output word_t      cmd_word,
    output word_t      caddr_word,
    output word_t      cdout_word,
    output word_t      cdin_word,
    output logic       wr_pulse,
    output logic       rd_pulse
);
    codec_st_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.wr_pulse = 1'b0;
        st_d.rd_pulse = 1'b0;
        if (wr_en) begin
            if (sel[IDX_CMD]) begin
                st_d.cmd             = wdata;
                st_d.cmd[CMD_GO_BIT] = 1'b0;
                if (wdata[CMD_GO_BIT]) begin
                    if (wdata[CMD_DIR_BIT]) begin
                        st_d.wr_pulse = 1'b1;
                    end else begin
                        st_d.rd_pulse = 1'b1;
                    end
                end
            end
            if (sel[IDX_CADDR]) st_d.caddr = wdata;
            if (sel[IDX_CDOUT]) st_d.cdout = wdata;
            if (sel[IDX_CDIN])  st_d.cdin  = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cmd_word   = st_q.cmd;
    assign caddr_word = st_q.caddr;
    assign cdout_word = st_q.cdout;
    assign cdin_word  = st_q.cdin;
    assign wr_pulse   = st_q.wr_pulse;
    assign rd_pulse   = st_q.rd_pulse;
endmodule

// File: rtl/audreg_chan.sv
module audreg_chan
    import audreg_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_en,
    input  logic  sel_ctrl,
    input  logic  sel_addr,
    input  logic  sel_rem,
    input  word_t wdata,
    input  logic  addr_load,
    input  word_t addr_next,
    input  logic  rem_load,
    input  word_t rem_next,
    output word_t ctrl_word,
    output word_t addr_word,
    output word_t rem_word,
    output logic  enable
);
    chan_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // engine loads first, so a bus write below overrides them
        if (addr_load) st_d.addr = addr_next;
        if (rem_load)  st_d.rem  = rem_next;
        if (wr_en) begin
            if (sel_ctrl) st_d.ctrl = wdata;
            if (sel_addr) st_d.addr = wdata;
            if (sel_rem)  st_d.rem  = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl_word = st_q.ctrl;
    assign addr_word = st_q.addr;
    assign rem_word  = st_q.rem;
    assign enable    = st_q.ctrl[CH_EN_BIT];
endmodule

// File: rtl/audreg_top.sv
module audreg_top
    import audreg_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [ADDR_W-1:0]              bus_addr,
    input  logic                           bus_wr,
    input  logic                           bus_rd,
    input  logic [WORD_W-1:0]              bus_wdata,
    output logic [WORD_W-1:0]              bus_rdata,
    output logic                           codec_wr_req,
    output logic                           codec_rd_req,
    output logic [WORD_W-1:0]              codec_reg_addr,
    output logic [WORD_W-1:0]              codec_reg_wdata,
    output logic [NUM_CH-1:0]              dma_enable,
    output logic [NUM_CH-1:0][WORD_W-1:0]  dma_addr,
    output logic [NUM_CH-1:0][WORD_W-1:0]  dma_remaining,
    input  logic [NUM_CH-1:0]              dma_addr_load,
    input  logic [NUM_CH-1:0][WORD_W-1:0]  dma_addr_next,
    input  logic [NUM_CH-1:0]              dma_rem_load,
    input  logic [NUM_CH-1:0][WORD_W-1:0]  dma_rem_next
);
    logic [NUM_WORDS-1:0] sel;
    word_t                words [NUM_WORDS];
    word_t                rdata_d, rdata_q;

    audreg_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    audreg_codec u_codec (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (bus_wr),
        .sel        (sel[3:0]),
        .wdata      (bus_wdata),
        .cmd_word   (words[IDX_CMD]),
        .caddr_word (words[IDX_CADDR]),
        .cdout_word (words[IDX_CDOUT]),
        .cdin_word  (words[IDX_CDIN]),
        .wr_pulse   (codec_wr_req),
        .rd_pulse   (codec_rd_req)
    );

    assign words[IDX_GAP] = '0;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        localparam int IC = chan_idx(c, CH_OFS_CTRL);
        localparam int IA = chan_idx(c, CH_OFS_ADDR);
        localparam int IR = chan_idx(c, CH_OFS_REM);

        audreg_chan u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (bus_wr),
            .sel_ctrl  (sel[IC]),
            .sel_addr  (sel[IA]),
            .sel_rem   (sel[IR]),
            .wdata     (bus_wdata),
            .addr_load (dma_addr_load[c]),
            .addr_next (dma_addr_next[c]),
            .rem_load  (dma_rem_load[c]),
            .rem_next  (dma_rem_next[c]),
            .ctrl_word (words[IC]),
            .addr_word (words[IA]),
            .rem_word  (words[IR]),
            .enable    (dma_enable[c])
        );

        assign dma_addr[c]      = words[IA];
        assign dma_remaining[c] = words[IR];
    end

    always_comb begin
        word_t picked;
        picked = '0;
        for (int i = 0; i < NUM_WORDS; i++) begin
            picked = picked | (words[i] & {WORD_W{sel[i]}});
        end
        rdata_d = rdata_q;
        if (bus_rd) rdata_d = picked;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= rdata_d;
        end
    end

    assign bus_rdata       = rdata_q;
    assign codec_reg_addr  = words[IDX_CADDR];
    assign codec_reg_wdata = words[IDX_CDOUT];
endmodule

// File: rtl/audreg_checker.sv
module audreg_checker
    import audreg_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-3:0] word_idx,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [1:0]        cmd_bits,
    input logic [WORD_W-1:0] bus_rdata,
    input logic              codec_wr_req,
    input logic              codec_rd_req,
    input logic [NUM_CH-1:0] dma_enable
);
    logic is_cmd, is_undef;
    assign is_cmd   = (int'(word_idx) == IDX_CMD);
    assign is_undef = (int'(word_idx) >= NUM_WORDS) || (int'(word_idx) == IDX_GAP);

    AST_WR_REQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        codec_wr_req |-> $past(bus_wr && is_cmd && cmd_bits == 2'b11)); // R3

    AST_RD_REQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        codec_rd_req |-> $past(bus_wr && is_cmd && cmd_bits == 2'b01)); // R4

    AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(codec_wr_req && codec_rd_req)); // R4

    AST_GO_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_rd && is_cmd) |-> !bus_rdata[CMD_GO_BIT]); // R5

    AST_GAP_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_rd && is_undef) |-> (bus_rdata == '0)); // R7

    AST_EN_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> $stable(dma_enable)); // R6
endmodule

bind audreg_top audreg_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .word_idx     (bus_addr[ADDR_W-1:2]),
    .bus_wr       (bus_wr),
    .bus_rd       (bus_rd),
    .cmd_bits     (bus_wdata[1:0]),
    .bus_rdata    (bus_rdata),
    .codec_wr_req (codec_wr_req),
    .codec_rd_req (codec_rd_req),
    .dma_enable   (dma_enable)
);

// File: tb/audreg_top_test.sv
`timescale 1ns/1ps
module audreg_top_test;
    localparam int AW = 6;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [AW-1:0]        bus_addr = '0;
    logic                 bus_wr = 1'b0, bus_rd = 1'b0;
    logic [31:0]          bus_wdata = '0;
    logic [31:0]          bus_rdata;
    logic                 codec_wr_req, codec_rd_req;
    logic [31:0]          codec_reg_addr, codec_reg_wdata;
    logic [1:0]           dma_enable;
    logic [1:0][31:0]     dma_addr, dma_remaining;
    logic [1:0]           dma_addr_load = '0, dma_rem_load = '0;
    logic [1:0][31:0]     dma_addr_next = '0, dma_rem_next = '0;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    audreg_top #(.ADDR_W(AW)) uut (.*);

    // behavioural reference
    logic [31:0] m_reg [0:10];
    logic [31:0] m_rdata;
    bit          m_wrp, m_rdp;
    int          m_ix;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 11; i++) m_reg[i] = '0;
            m_rdata = '0; m_wrp = 0; m_rdp = 0;
        end else begin
            m_ix = int'(bus_addr) / 4;
            m_wrp = 0; m_rdp = 0;
            if (bus_rd) m_rdata = (m_ix < 11 && m_ix != 7) ? m_reg[m_ix] : 32'h0;
            for (int c = 0; c < 2; c++) begin
                if (dma_addr_load[c]) m_reg[5 + 4*c] = dma_addr_next[c];
                if (dma_rem_load[c])  m_reg[6 + 4*c] = dma_rem_next[c];
            end
            if (bus_wr && m_ix < 11 && m_ix != 7) begin
                if (m_ix == 0) begin
                    m_reg[0] = bus_wdata & 32'hFFFF_FFFE;
                    if (bus_wdata[0]) begin
                        if (bus_wdata[1]) m_wrp = 1; else m_rdp = 1;
                    end
                end else begin
                    m_reg[m_ix] = bus_wdata;
                end
            end
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R2 rdata", bus_rdata, m_rdata);
            check("R3 wr_req", 32'(codec_wr_req), 32'(m_wrp));
            check("R4 rd_req", 32'(codec_rd_req), 32'(m_rdp));
            check("R10 caddr", codec_reg_addr, m_reg[1]);
            check("R10 cdout", codec_reg_wdata, m_reg[2]);
            for (int c = 0; c < 2; c++) begin
                check("R6 enable", 32'(dma_enable[c]), 32'(m_reg[4 + 4*c][0]));
                check("R9 addr", dma_addr[c], m_reg[5 + 4*c]);
                check("R9 rem", dma_remaining[c], m_reg[6 + 4*c]);
            end
        end
    end

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = AW'(a); bus_wdata = d; bus_wr = 1;
        @(posedge clk); #1;
        bus_wr = 0;
    endtask

    task automatic rd_chk(input int a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_addr = AW'(a); bus_rd = 1;
        @(posedge clk); #1;
        bus_rd = 0;
        @(negedge clk);
        check(tag, bus_rdata, exp);
    endtask

    task automatic reset_chk();
        @(negedge clk); rst_n = 0;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        check("R8 rst rdata", bus_rdata, 0);
        check("R8 rst en", 32'(dma_enable), 0);
        check("R8 rst req", 32'({codec_wr_req, codec_rd_req}), 0);
        check("R8 rst caddr", codec_reg_addr, 0);
        check("R8 rst dmaaddr", dma_addr[1], 0);
        rst_n = 1;
    endtask

    task automatic pulse_chk(input logic [31:0] d, input bit ew, input bit er, input string tag);
        wr(0, d);
        check(tag, 32'({codec_wr_req, codec_rd_req}), 32'({ew, er}));
        @(posedge clk); #1;
        check(tag, 32'({codec_wr_req, codec_rd_req}), 0);
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            done = 1;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        reset_chk();
        for (int i = 0; i < 11; i++) rd_chk(4*i, 0, "R8 word zero");

        // fill every word with a distinct value and read it back (R1)
        for (int i = 1; i < 11; i++) if (i != 7) wr(4*i, 32'hA500_0000 + 32'(i) * 32'h111);
        for (int i = 1; i < 11; i++)
            rd_chk(4*i, (i == 7) ? 32'h0 : 32'hA500_0000 + 32'(i) * 32'h111, "R1 map");
        rd_chk(4*5 + 3, 32'hA500_0000 + 32'h555, "R1 low bits ignored");
        wr(4*9 + 2, 32'h1234_5678);
        rd_chk(4*9, 32'h1234_5678, "R1 alias write");

        // command word
        pulse_chk(32'h0000_0003, 1, 0, "R3 write pulse");
        pulse_chk(32'h0000_0001, 0, 1, "R4 read pulse");
        pulse_chk(32'h0000_0002, 0, 0, "R4 no go no pulse");
        pulse_chk(32'hDEAD_BEEF, 1, 0, "R3 write pulse with data");
        rd_chk(0, 32'hDEAD_BEEE, "R5 go bit hidden");
        wr(0, 32'h8000_00F1);
        rd_chk(0, 32'h8000_00F0, "R5 others kept");
        wr(0, 32'h3); wr(0, 32'h1);  // back-to-back requests

        // unused slots (R7)
        wr(4*7, 32'hFFFF_FFFF);
        rd_chk(4*7, 0, "R7 gap read");
        for (int i = 11; i < 16; i++) begin
            wr(4*i, 32'hCAFE_0000 + 32'(i));
            rd_chk(4*i, 0, "R7 above range");
        end
        rd_chk(4*6, 32'hA500_0000 + 32'h666, "R7 neighbour untouched");

        // channel enables (R6)
        wr(4*4, 32'h1);
        check("R6 dn en", 32'(dma_enable), 32'b01);
        wr(4*8, 32'h5);
        check("R6 both en", 32'(dma_enable), 32'b11);
        wr(4*4, 32'h4);
        check("R6 dn off", 32'(dma_enable), 32'b10);

        // engine loads and priority (R9)
        @(negedge clk);
        dma_addr_load = 2'b11; dma_addr_next[0] = 32'h1000; dma_addr_next[1] = 32'h2000;
        dma_rem_load = 2'b01; dma_rem_next[0] = 32'h40;
        @(posedge clk); #1;
        dma_addr_load = 0; dma_rem_load = 0;
        rd_chk(4*5, 32'h1000, "R9 load dn addr");
        rd_chk(4*9, 32'h2000, "R9 load up addr");
        rd_chk(4*6, 32'h40, "R9 load dn rem");
        @(negedge clk);
        dma_rem_load = 2'b10; dma_rem_next[1] = 32'h77;
        bus_addr = AW'(4*10); bus_wdata = 32'h99; bus_wr = 1;
        @(posedge clk); #1;
        bus_wr = 0; dma_rem_load = 0;
        rd_chk(4*10, 32'h99, "R9 bus write wins");

        // mid-run reset
        reset_chk();
        for (int i = 0; i < 11; i++) rd_chk(4*i, 0, "R8 cleared");

        repeat (3) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule